// File: doc/BRIEF.md
# Hierarchical vertical-crosswise multiplier

This block multiplies two unsigned operands and returns their full-width product with no clock and no handshake. The product settles one propagation delay after the operands change. Each operand is cut into an upper and a lower half. Four half-width tiles form the four cross products, and each tile repeats the same split until the tiles reach a small base width.

At the base width, the product is built one result column at a time. Each column adds every bit product whose two bit indices sum to that column, plus the carry left over from the column below. The least significant bit of that column total becomes the result bit, and the rest of the total carries forward. The lowest column starts with a carry of zero.

Above the base width, every tile merges its four sub-products with two adders: one adds the two cross terms, and the other places that sum between the high and low products. A parameter selects the adder used everywhere in the tree:
- a ripple-carry chain;
- carry-lookahead built from groups of four bits, with the carries inside each group fully expanded;
- a Kogge-Stone parallel-prefix network.

Top module: `vcm_mult16`

## Requirements
- R1: For every pair of unsigned 16-bit operands, `product` equals op_a × op_b as a 32-bit unsigned value. This value is AH·BH·2^16 + (AH·BL + AL·BH)·2^8 + AL·BL, where H and L are the upper and lower bytes.
- R2: When either operand is zero, `product` is zero.
- R3: When one operand is 1, `product` equals the other operand zero-extended to 32 bits.
- R4: 0xFFFF × 0xFFFF gives 0xFFFE0001, which exercises the longest carry chain through every merge adder.
- R5: With ARCH set to ADD_RIPPLE (carry passed bit to bit), the product matches R1 for all operands.
- R6: With ARCH set to ADD_LOOKAHEAD (4-bit groups, generate = a AND b, propagate = a XOR b, carries expanded within each group), the product matches R1.
- R7: With ARCH set to ADD_PREFIX (Kogge-Stone prefix of generate/propagate pairs, sum bit = propagate XOR incoming carry), the product matches R1.
- R8: The block is combinational. A change of operands shows up on `product` within the same clock period, with no clock edge needed.
- R9: Operands that use only the upper byte or only the lower byte give products shifted by exactly 8 or 16 bits. For example, 0xFF00 × 0x00FF = 0x00FE0100 and 0xFF00 × 0xFF00 = 0xFE010000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | Unsigned multiplicand |
| op_b | input | 16 | Unsigned multiplier |
| product | output | 32 | Unsigned product op_a × op_b |

## Verification
The bench builds three copies of the block, one with each of ADD_RIPPLE, ADD_LOOKAHEAD and ADD_PREFIX, and drives the same operands into all three. This brings the ripple chain, the grouped lookahead carries and the prefix tree under the same tables and random operands. A fault in any one adder variant therefore shows as a mismatch only on that copy. All three copies keep the default base tile width of 2, so the column-sum base case and three levels of recursion (16, 8, 4) are all exercised.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  typedef enum logic [1:0] {
    ADD_RIPPLE    = 2'd0,
    ADD_LOOKAHEAD = 2'd1,
    ADD_PREFIX    = 2'd2
  } adder_arch_e;
endpackage

// File: rtl/vcm_adder.sv
module vcm_adder #(
  parameter int                   W    = 8,
  parameter vcm_pkg::adder_arch_e ARCH = vcm_pkg::ADD_PREFIX
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int NG = (W + 3) / 4;
  localparam int WP = NG * 4;
  localparam int LV = (W > 1) ? $clog2(W) : 1;

  logic [W:0] ref_sum;
  assign ref_sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

  generate
    if (ARCH == vcm_pkg::ADD_RIPPLE) begin : g_ripple
      always_comb begin
        logic [W:0] c;
        c = '0;
        c[0] = cin;
        for (int i = 0; i < W; i++) begin
          sum[i]   = a[i] ^ b[i] ^ c[i];
          c[i+1]   = (a[i] & b[i]) | ((a[i] ^ b[i]) & c[i]);
        end
        cout = c[W];
      end
      always_comb begin
        assert_rca_sum_R5: assert ({cout, sum} == ref_sum)
          else $error("ripple adder sum mismatch");
      end
    end else if (ARCH == vcm_pkg::ADD_LOOKAHEAD) begin : g_lookahead
      logic [WP-1:0] ap, bp;
      assign ap = WP'(a);
      assign bp = WP'(b);
      always_comb begin
        logic [WP-1:0] g, p;
        logic [WP:0]   c;
        logic          term, chain;
        g = ap & bp;
        p = ap ^ bp;
        c = '0;
        c[0] = cin;
        for (int grp = 0; grp < NG; grp++) begin
          for (int k = 0; k < 4; k++) begin
            term = 1'b0;
            for (int m = 0; m <= k; m++) begin
              chain = g[grp*4 + m];
              for (int n = m + 1; n <= k; n++) chain = chain & p[grp*4 + n];
              term = term | chain;
            end
            chain = c[grp*4];
            for (int n = 0; n <= k; n++) chain = chain & p[grp*4 + n];
            c[grp*4 + k + 1] = term | chain;
          end
        end
        for (int i = 0; i < W; i++) sum[i] = p[i] ^ c[i];
        cout = c[W];
      end
      always_comb begin
        assert_cla_sum_R6: assert ({cout, sum} == ref_sum)
          else $error("lookahead adder sum mismatch");
      end
    end else begin : g_prefix
      always_comb begin
        logic [W-1:0] p0, gg, pp, gn, pn;
        int d;
        p0 = a ^ b;
        gg = a & b;
        pp = p0;
        gg[0] = gg[0] | (p0[0] & cin);
        for (int s = 0; s < LV; s++) begin
          d = 1 << s;
          for (int i = 0; i < W; i++) begin
            if (i >= d) begin
              gn[i] = gg[i] | (pp[i] & gg[i-d]);
              pn[i] = pp[i] & pp[i-d];
            end else begin
              gn[i] = gg[i];
              pn[i] = pp[i];
            end
          end
          gg = gn;
          pp = pn;
        end
        sum[0] = p0[0] ^ cin;
        for (int i = 1; i < W; i++) sum[i] = p0[i] ^ gg[i-1];
        cout = gg[W-1];
      end
      always_comb begin
        assert_ks_sum_R7: assert ({cout, sum} == ref_sum)
          else $error("prefix adder sum mismatch");
      end
    end
  endgenerate
endmodule

// File: rtl/vcm_tile.sv
module vcm_tile #(
  parameter int                   N    = 16,
  parameter int                   BASE = 2,
  parameter vcm_pkg::adder_arch_e ARCH = vcm_pkg::ADD_PREFIX
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] prod
);
  localparam int PW = 2 * N;
  localparam int H  = N / 2;
  localparam int CW = 2 * $clog2(N + 1) + 2;

  generate
    if (N <= BASE) begin : g_base
      always_comb begin
        logic [CW-1:0] acc, carry;
        int j;
        prod  = '0;
        carry = '0;
        for (int col = 0; col < PW - 1; col++) begin
          acc = carry;
          for (int i = 0; i < N; i++) begin
            j = col - i;
            if (j >= 0 && j < N) acc = acc + {{(CW-1){1'b0}}, a[i] & b[j]};
          end
          prod[col] = acc[0];
          carry     = acc >> 1;
        end
        prod[PW-1] = carry[0];
      end
    end else begin : g_split
      logic [N-1:0]  p_hh, p_hl, p_lh, p_ll;
      logic [N-1:0]  mid_sum;
      logic          mid_cout;
      logic [PW-1:0] mid_shift;
      logic          merge_cout;

      vcm_tile #(.N(H), .BASE(BASE), .ARCH(ARCH)) u_hh (.a(a[N-1:H]), .b(b[N-1:H]), .prod(p_hh));
      vcm_tile #(.N(H), .BASE(BASE), .ARCH(ARCH)) u_hl (.a(a[N-1:H]), .b(b[H-1:0]), .prod(p_hl));
      vcm_tile #(.N(H), .BASE(BASE), .ARCH(ARCH)) u_lh (.a(a[H-1:0]), .b(b[N-1:H]), .prod(p_lh));
      vcm_tile #(.N(H), .BASE(BASE), .ARCH(ARCH)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .prod(p_ll));

      vcm_adder #(.W(N), .ARCH(ARCH)) u_mid (
        .a(p_hl), .b(p_lh), .cin(1'b0), .sum(mid_sum), .cout(mid_cout)
      );

      assign mid_shift = PW'({mid_cout, mid_sum, {H{1'b0}}});

      vcm_adder #(.W(PW), .ARCH(ARCH)) u_merge (
        .a({p_hh, p_ll}), .b(mid_shift), .cin(1'b0), .sum(prod), .cout(merge_cout)
      );

      always_comb begin
        assert_no_overflow_R1: assert (merge_cout == 1'b0)
          else $error("tile merge overflowed");
      end
    end
  endgenerate

  always_comb begin
    assert_tile_prod_R1: assert (prod == PW'(a) * PW'(b))
      else $error("tile product mismatch");
  end
endmodule

// File: rtl/vcm_mult16.sv
module vcm_mult16 #(
  parameter int                   OPW  = 16,
  parameter int                   BASE = 2,
  parameter vcm_pkg::adder_arch_e ARCH = vcm_pkg::ADD_PREFIX
) (
  input  logic [OPW-1:0]   op_a,
  input  logic [OPW-1:0]   op_b,
  output logic [2*OPW-1:0] product
);
  localparam int PW = 2 * OPW;

  vcm_tile #(.N(OPW), .BASE(BASE), .ARCH(ARCH)) u_root (
    .a(op_a), .b(op_b), .prod(product)
  );

  always_comb begin
    assert_zero_R2: assert (!((op_a == '0) || (op_b == '0)) || (product == '0))
      else $error("zero operand gave nonzero product");
    assert_unit_a_R3: assert ((op_a != OPW'(1)) || (product == PW'(op_b)))
      else $error("unit op_a mismatch");
    assert_unit_b_R3: assert ((op_b != OPW'(1)) || (product == PW'(op_a)))
      else $error("unit op_b mismatch");
    assert_allones_R4: assert (!((&op_a) && (&op_b)) ||
                               (product == {{(OPW-1){1'b1}}, 1'b0, {(OPW-1){1'b0}}, 1'b1}))
      else $error("all-ones product mismatch");
  end
endmodule

// File: tb/vcm_mult16_tb.sv
module vcm_mult16_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;
  localparam int NRAND      = 300;

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic [31:0] p;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{16'h0000, 16'h1234, 32'h0000_0000},
    '{16'h0001, 16'hABCD, 32'h0000_ABCD},
    '{16'hFFFF, 16'hFFFF, 32'hFFFE_0001},
    '{16'h0100, 16'h0100, 32'h0001_0000},
    '{16'h00FF, 16'h00FF, 32'h0000_FE01},
    '{16'hFF00, 16'hFF00, 32'hFE01_0000},
    '{16'h1234, 16'h5678, 32'h0626_0060},
    '{16'h8000, 16'h8000, 32'h4000_0000},
    '{16'h00FF, 16'hFF00, 32'h00FE_0100},
    '{16'hFFFF, 16'h0001, 32'h0000_FFFF}
  };

  logic        clk;
  logic [15:0] op_a, op_b;
  logic [31:0] prod_ks, prod_rca, prod_cla;
  int          n_checks, n_fails, cycles;

  vcm_mult16 #(.ARCH(vcm_pkg::ADD_PREFIX))    u_dut     (.op_a(op_a), .op_b(op_b), .product(prod_ks));
  vcm_mult16 #(.ARCH(vcm_pkg::ADD_RIPPLE))    u_dut_rca (.op_a(op_a), .op_b(op_b), .product(prod_rca));
  vcm_mult16 #(.ARCH(vcm_pkg::ADD_LOOKAHEAD)) u_dut_cla (.op_a(op_a), .op_b(op_b), .product(prod_cla));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: a=%h b=%h actual=%h expected=%h", tag, op_a, op_b, got, exp);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    op_a = a;
    op_b = b;
    #(CLK_PERIOD/4);
  endtask

  task automatic check_all(input string tag, input logic [31:0] exp);
    check({tag, "/R7 prefix"}, prod_ks, exp);
    check({tag, "/R5 ripple"}, prod_rca, exp);
    check({tag, "/R6 lookahead"}, prod_cla, exp);
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WD_LIMIT) begin
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WD_LIMIT);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] ra, rb;
    n_checks = 0;
    n_fails  = 0;
    op_a = '0;
    op_b = '0;

    // Table walk: R1 across every adder variant
    foreach (VECS[i]) begin
      apply(VECS[i].a, VECS[i].b);
      check_all("R1 table", VECS[i].p);
    end

    // R2: zero on either side
    apply(16'h0000, 16'hFFFF); check_all("R2 zero a", 32'h0);
    apply(16'hBEEF, 16'h0000); check_all("R2 zero b", 32'h0);

    // R3: unit operand
    apply(16'h0001, 16'h8001); check_all("R3 unit a", 32'h0000_8001);
    apply(16'hC3A5, 16'h0001); check_all("R3 unit b", 32'h0000_C3A5);

    // R4: all ones
    apply(16'hFFFF, 16'hFFFF); check_all("R4 allones", 32'hFFFE_0001);

    // R9: byte-isolated operands
    apply(16'hFF00, 16'h00FF); check_all("R9 hi x lo", 32'h00FE_0100);
    apply(16'h00FF, 16'hFF00); check_all("R9 lo x hi", 32'h00FE_0100);
    apply(16'hFF00, 16'hFF00); check_all("R9 hi x hi", 32'hFE01_0000);

    // R8: combinational response without an edge
    @(negedge clk);
    op_a = 16'h0003; op_b = 16'h0005;
    #1;
    check("R8 comb first", prod_ks, 32'd15);
    op_a = 16'h0100; op_b = 16'h0007;
    #1;
    check("R8 comb second", prod_ks, 32'h0000_0700);

    // R1 random, all variants
    for (int k = 0; k < NRAND; k++) begin
      ra = 16'($urandom);
      rb = 16'($urandom);
      apply(ra, rb);
      check_all("R1 random", 32'(ra) * 32'(rb));
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule